// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Generator

This block supplies all bit-rate timing for a serial port that can run asynchronously, at normal or doubled speed, or as a synchronous clock master. A 12-bit divisor sets a reloading down-counter that runs on the system clock. Each time that counter underflows it produces a prescale pulse. A second divider then turns these pulses into the receiver's oversampling tick and sample index, the transmitter's bit tick and, in synchronous master mode, the serial clock driven to the line.

Three post-divide factors share the one divisor. Normal asynchronous mode divides by 16, double-speed mode by 8, and synchronous master mode by 2. The double-speed select is honoured only in asynchronous mode. A change of divisor or mode waits for the next counter reload. At that reload the post-divider restarts from zero, so the old rate never yields a shortened bit.

Top module: `baud_gen`

## Requirements
- R1: The prescaler reloads from `divisor` (0 to 4095) and emits one prescale pulse every `divisor`+1 clock cycles. With `divisor` = 0 a pulse occurs on every cycle. In asynchronous modes every prescale pulse appears on `sample_tick`.
- R2: In normal asynchronous mode (`sync_mode` = 0, `dbl_speed` = 0), `bit_tick` pulses once every 16×(`divisor`+1) cycles. The first pulse comes 16×(`divisor`+1)−1 cycles after the first cycle out of reset.
- R3: In double-speed asynchronous mode (`sync_mode` = 0, `dbl_speed` = 1), `bit_tick` pulses once every 8×(`divisor`+1) cycles. The first pulse comes 8×(`divisor`+1)−1 cycles after reset.
- R4: In synchronous master mode (`sync_mode` = 1), `sclk` toggles on every prescale pulse, giving equal high and low phases of `divisor`+1 cycles. `sclk` starts low. The pulse that raises `sclk` is a `sample_tick`. The pulse that lowers it is a `bit_tick`, so bits are spaced 2×(`divisor`+1) cycles apart.
- R5: `sample_idx` gives the position of each `sample_tick` within the bit. It counts 0 to 15 in normal mode and 0 to 7 in double-speed mode, and `bit_tick` coincides with the last index. In synchronous mode `sample_idx` is 0.
- R6: When `sync_mode` = 1, `dbl_speed` has no effect on any output.
- R7: A change of `divisor`, `sync_mode` or `dbl_speed` takes effect at the next prescale pulse. That pulse produces no tick, reloads the counter with the new divisor, clears the sample index and drives `sclk` low. The following bit therefore lasts a full new bit period.
- R8: While `rst` is high and in the first cycle after it, `bit_tick` is 0 and `sclk` is 0. During reset, `sample_tick` and `sample_idx` are also 0.
- R9: In asynchronous modes `sclk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | 12 | Prescale divisor, period = divisor+1 cycles |
| dbl_speed | input | 1 | Double-speed select (asynchronous only) |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| sample_tick | output | 1 | One-cycle receiver sampling pulse |
| sample_idx | output | 4 | Sample position within the bit |
| sclk | output | 1 | Serial clock in synchronous master mode |

## Verification
The divisor extremes are the cases most likely to expose a fault. With a divisor of 0, a counter that waits one idle cycle before reloading would halve the rate. With a divisor of 4095, a narrowed counter would wrap early, and the gap to the first tick would show it. Each mode is checked for its own post-divide factor: a design that ignored `dbl_speed` would space ticks 16 apart, and one that honoured it in synchronous mode would break the sclk period. A mid-run divisor change tests the restart: a design that failed to clear the index would emit a short bit right after the change.

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int DIV_W   = 12,
  parameter int OS_NORM = 16,
  parameter int OS_DBL  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DIV_W-1:0]           divisor,
  input  logic                       dbl_speed,
  input  logic                       sync_mode,
  output logic                       bit_tick,
  output logic                       sample_tick,
  output logic [$clog2(OS_NORM)-1:0] sample_idx,
  output logic                       sclk
);
  localparam int IDX_W = $clog2(OS_NORM);
  localparam logic [1:0] M_NORM = 2'd0;
  localparam logic [1:0] M_DBL  = 2'd1;
  localparam logic [1:0] M_SYNC = 2'd2;
  localparam logic [IDX_W-1:0] LAST_NORM = IDX_W'(OS_NORM - 1);
  localparam logic [IDX_W-1:0] LAST_DBL  = IDX_W'(OS_DBL - 1);

  logic [DIV_W-1:0] cnt, div_q;
  logic [1:0]       mode_q, mode_in;
  logic [IDX_W-1:0] pos, last;
  logic             sclk_q, pulse, restart, live, is_sync;

  assign mode_in = sync_mode ? M_SYNC : (dbl_speed ? M_DBL : M_NORM);
  assign pulse   = !rst && (cnt == '0);
  assign restart = (divisor != div_q) || (mode_in != mode_q);
  assign live    = pulse && !restart;
  assign is_sync = (mode_q == M_SYNC);
  assign last    = (mode_q == M_DBL) ? LAST_DBL : LAST_NORM;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= divisor;
      div_q  <= divisor;
      mode_q <= mode_in;
      pos    <= '0;
      sclk_q <= 1'b0;
    end else if (pulse) begin
      cnt <= divisor;
      if (restart) begin
        div_q  <= divisor;
        mode_q <= mode_in;
        pos    <= '0;
        sclk_q <= 1'b0;
      end else if (is_sync) begin
        sclk_q <= ~sclk_q;
      end else begin
        pos <= (pos == last) ? '0 : pos + 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign sample_tick = live && (!is_sync || !sclk_q);
  assign bit_tick    = live && (is_sync ? sclk_q : (pos == last));
  assign sample_idx  = is_sync ? '0 : pos;
  assign sclk        = sclk_q;

  // R1
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && divisor == '0 && !restart) |=> pulse);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && dbl_speed && !sync_mode) |-> (sample_idx < IDX_W'(OS_DBL)));

  // R2
  bit_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !sync_mode) |->
      (sample_tick && sample_idx == (dbl_speed ? LAST_DBL : LAST_NORM)));

  // R4
  sclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(pulse));

  // R9
  async_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && !sync_mode) |-> !sclk);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && restart) |-> (!bit_tick && !sample_tick));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bit_tick && !sclk));
endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] divisor = '0;
  logic dbl_speed = 1'b0;
  logic sync_mode = 1'b0;
  logic bit_tick, sample_tick, sclk;
  logic [3:0] sample_idx;

  int n_chk = 0;
  int n_err = 0;
  int k = 0;          // cycles since reset release
  bit watchdog_hit = 0;

  // behavioural reference state
  int m_cnt = 0, m_div = 0, m_mode = 0, m_pos = 0, m_sclk = 0;
  bit model_on = 0;

  baud_gen dut_i (
    .clk(clk), .rst(rst), .divisor(divisor), .dbl_speed(dbl_speed),
    .sync_mode(sync_mode), .bit_tick(bit_tick), .sample_tick(sample_tick),
    .sample_idx(sample_idx), .sclk(sclk)
  );

  always #10 clk = ~clk;

  function automatic int cur_mode();
    return sync_mode ? 2 : (dbl_speed ? 1 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, k);
    end
  endtask

  // cycle-by-cycle reference, compared at the falling edge
  always @(negedge clk) begin
    int e_bt, e_st, e_idx, e_sclk, lastp;
    bit pul, rs, lv;
    if (rst) begin
      check(bit_tick == 0 && sample_tick == 0 && sclk == 0 && sample_idx == 0,
            "R8 reset outputs", {bit_tick, sample_tick, sclk}, 0);
      m_cnt = divisor; m_div = divisor; m_mode = cur_mode(); m_pos = 0; m_sclk = 0;
      model_on = 1;
      k = 0;
    end else if (model_on) begin
      lastp = (m_mode == 1) ? 7 : 15;
      pul = (m_cnt == 0);
      rs  = (divisor != m_div) || (cur_mode() != m_mode);
      lv  = pul && !rs;
      e_st  = (lv && (m_mode != 2 || m_sclk == 0)) ? 1 : 0;
      e_bt  = (lv && ((m_mode == 2) ? (m_sclk == 1) : (m_pos == lastp))) ? 1 : 0;
      e_idx = (m_mode == 2) ? 0 : m_pos;
      e_sclk = m_sclk;
      check(sample_tick == e_st, "R1/R5 sample_tick", sample_tick, e_st);
      check(bit_tick == e_bt, "R2/R3/R4 bit_tick", bit_tick, e_bt);
      check(sample_idx == e_idx, "R5 sample_idx", sample_idx, e_idx);
      check(sclk == e_sclk, "R4/R9 sclk", sclk, e_sclk);
      if (pul) begin
        m_cnt = divisor;
        if (rs) begin
          m_div = divisor; m_mode = cur_mode(); m_pos = 0; m_sclk = 0;
        end else if (m_mode == 2) m_sclk = 1 - m_sclk;
        else m_pos = (m_pos == lastp) ? 0 : m_pos + 1;
      end else m_cnt--;
      k++;
    end
  end

  task automatic do_reset(input int d, input bit sy, input bit db);
    @(posedge clk); #1;
    rst = 1; divisor = 12'(d); sync_mode = sy; dbl_speed = db;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 0;
  endtask

  // wait for next bit tick, returning the cycle index where it was seen
  task automatic next_tick(output int at);
    do @(negedge clk); while (!(bit_tick === 1'b1));
    #1 at = k - 1;
  endtask

  task automatic run_case(input int d, input bit sy, input bit db, input int factor,
                          input int n_iv, input string req);
    int t0, t1;
    do_reset(d, sy, db);
    @(negedge clk); #1;
    check(bit_tick == 0 && sclk == 0, {req, " first cycle after reset (R8)"}, bit_tick, 0);
    next_tick(t0);
    check(t0 == factor * (d + 1) - 1, {req, " first tick latency"}, t0, factor * (d + 1) - 1);
    for (int i = 0; i < n_iv; i++) begin
      next_tick(t1);
      check(t1 - t0 == factor * (d + 1), {req, " tick interval"}, t1 - t0, factor * (d + 1));
      t0 = t1;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    watchdog_hit = 1;
  end

  initial begin : stim
    int t0, t1, t2, cnt_s;
    fork
      begin
        // R1: divisor 0 gives a prescale pulse each cycle
        do_reset(0, 0, 0);
        cnt_s = 0;
        for (int i = 0; i < 32; i++) begin
          @(negedge clk);
          if (sample_tick) cnt_s++;
        end
        check(cnt_s == 32, "R1 zero divisor sample rate", cnt_s, 32);

        run_case(0, 0, 0, 16, 2, "R2 normal d=0");
        run_case(5, 0, 0, 16, 2, "R2 normal d=5");
        run_case(0, 0, 1, 8, 2, "R3 double d=0");
        run_case(100, 0, 1, 8, 2, "R3 double d=100");
        run_case(0, 1, 0, 2, 3, "R4 sync d=0");
        run_case(7, 1, 0, 2, 3, "R4 sync d=7");
        run_case(9, 1, 1, 2, 3, "R6 sync with double set");
        run_case(4095, 1, 0, 2, 1, "R4 sync d=4095");
        run_case(4095, 0, 0, 16, 0, "R2 normal d=4095");

        // R7: divisor change mid-run restarts cleanly
        run_case(3, 0, 0, 16, 1, "R7 pre-change");
        @(posedge clk); #1;
        divisor = 12'd1;
        t0 = k - 1;
        next_tick(t1);
        check(t1 - t0 > 16 * 2, "R7 no truncated bit after change", t1 - t0, 33);
        next_tick(t2);
        check(t2 - t1 == 32, "R7 new period", t2 - t1, 32);

        // R7/R9: switch sync to async mid-run
        run_case(2, 1, 0, 2, 1, "R9 pre-switch sync");
        @(posedge clk); #1;
        sync_mode = 0;
        next_tick(t1);
        check(sclk == 0, "R9 sclk low in async", sclk, 0);
        next_tick(t2);
        check(t2 - t1 == 48, "R7 async period after switch", t2 - t1, 48);
      end
      begin
        wait (watchdog_hit);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule